// File: doc/BRIEF.md
# Adaptive Prefetch Degree Controller

This block decides how many sequential blocks a prefetcher should fetch ahead of a missing block. It watches the prefetch traffic and measures how many of the prefetched lines are later touched. It keeps three counters: a reply counter, a hit counter and the current degree. It also keeps two flags for every cache line: a "came from a prefetch" flag and a "could have been prefetched" flag. Every 2^CNT_W prefetch replies it compares the hit count with a high threshold and a low threshold. It then raises the degree, lowers it or leaves it as it is.

A degree of zero switches prefetching off. While it is off, the block keeps measuring. Each demand fill marks its line as one that could have been prefetched, and it counts as a reply. A later read miss whose preceding block hits on such a marked line counts as a hit. A productive stretch can therefore bring the degree back up from zero without any help from outside.

The cache tags, the data path and the engine that issues prefetch requests are outside this block. They report events through single-cycle strobes, and each strobe carries a line index. The block returns the degree and an enable flag, both registered.

Top module: `pf_degree_ctrl`

## Requirements
- R1: After a synchronous reset the degree is 1 and `pf_en` is 1. The reply count, the hit count and every per-line flag are 0.
- R2: Each `rply_vld` strobe adds one to the reply count. A reply that carries data and a reply that is a negative acknowledge count the same way.
- R3: `pfill_vld` sets the prefetch flag of line `pfill_idx`. An `acc_vld` to a line whose prefetch flag is set adds one to the hit count and clears that flag. A second access to the same line adds nothing.
- R4: The reply and hit counts are CNT_W bits wide and wrap modulo 2^CNT_W. One cycle can add up to two to the reply count (a reply plus a demand fill while prefetching is off). The degree changes only in a cycle in which the reply count wraps.
- R5: In the cycle in which the reply count wraps, the hit count is compared with the thresholds. Above HI_TH the degree goes up by one. Below LO_TH it goes down by one. Otherwise it stays the same. The hit count is cleared in every case.
- R6: `pf_en` is 1 exactly when the degree is nonzero.
- R7: The degree never rises above LA_MAX and never falls below 0.
- R8: While the degree is 0, each `dfill_vld` sets the zero flag of line `dfill_idx` and adds one to the reply count.
- R9: A lookup of the previous block (`prev_vld`) with `prev_hit`=1 on a line whose zero flag is set adds one to the hit count and clears that flag. With `prev_hit`=0 the lookup has no effect.
- R10: An access to a line clears its zero flag when the degree is nonzero. An access while the degree is 0 leaves the zero flag alone.
- R11: Events in the same cycle combine as follows:
  - A set of a flag wins over a clear of the same flag.
  - An access reads the prefetch flag as it was before the cycle.
  - A hit counted in the wrap cycle is included in that cycle's comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rply_vld | input | 1 | A prefetch reply arrived (data or negative acknowledge) |
| pfill_vld | input | 1 | A line was filled by a prefetch |
| pfill_idx | input | IDX_W | Line filled by the prefetch |
| acc_vld | input | 1 | A line was accessed |
| acc_idx | input | IDX_W | Line that was accessed |
| dfill_vld | input | 1 | A line was filled by a demand read miss |
| dfill_idx | input | IDX_W | Line filled by the demand miss |
| prev_vld | input | 1 | The block before a read miss was looked up |
| prev_hit | input | 1 | That previous-block lookup hit |
| prev_idx | input | IDX_W | Line holding the previous block |
| degree | output | LA_W | Current prefetch degree |
| pf_en | output | 1 | Prefetching is enabled |

## Verification
The hardest state to reach from the ports is recovery from degree zero. It needs three stretches of stimulus in order:
1. A window of replies with no hits pulls the degree to zero.
2. Demand fills then plant zero flags and advance the reply count. One cycle carries both a reply and a demand fill.
3. Previous-block lookups cash in those zero flags. One lookup misses, and one access is made while prefetching is off.

The window that follows is tuned so that the hit count lands exactly on the high threshold. The degree therefore holds unless a zero flag that should already have been cleared is counted again. The directed part ends with a random phase, and a behavioural model is compared against the outputs on every cycle.

// File: rtl/pfdeg_pkg.sv
package pfdeg_pkg;
  typedef enum logic [1:0] {
    ADJ_HOLD = 2'd0,
    ADJ_UP   = 2'd1,
    ADJ_DOWN = 2'd2
  } adj_e;
endpackage

// File: rtl/pfdeg_linebits.sv
// Per-line flags: prefetched-and-unused, and could-have-been-prefetched.
module pfdeg_linebits #(
  parameter int LINES = 64,
  parameter int IW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pf_on,
  input  logic          pfill_vld,
  input  logic [IW-1:0] pfill_idx,
  input  logic          acc_vld,
  input  logic [IW-1:0] acc_idx,
  input  logic          dfill_vld,
  input  logic [IW-1:0] dfill_idx,
  input  logic          prev_vld,
  input  logic          prev_hit,
  input  logic [IW-1:0] prev_idx,
  output logic          pb_use,
  output logic          zb_use
);
  logic [LINES-1:0] pbit;
  logic [LINES-1:0] zbit;

  // reads see the flags as they were before this cycle
  assign pb_use = acc_vld & pbit[acc_idx];
  assign zb_use = prev_vld & prev_hit & zbit[prev_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        pbit[g] <= 1'b0;
      end else if (pfill_vld && pfill_idx == IW'(g)) begin
        pbit[g] <= 1'b1;
      end else if (acc_vld && acc_idx == IW'(g)) begin
        pbit[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        zbit[g] <= 1'b0;
      end else if (dfill_vld && !pf_on && dfill_idx == IW'(g)) begin
        zbit[g] <= 1'b1;
      end else if ((acc_vld && pf_on && acc_idx == IW'(g)) ||
                   (prev_vld && prev_hit && prev_idx == IW'(g))) begin
        zbit[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfdeg_window.sv
// Reply and hit counters; issues an adjustment when the reply count wraps.
module pfdeg_window
  import pfdeg_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int HI_TH = 12,
  parameter int LO_TH = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] p_inc,
  input  logic [1:0] u_inc,
  output adj_e       adj
);
  logic [CNT_W-1:0] pcnt, ucnt;
  logic [CNT_W:0]   psum;
  logic [CNT_W-1:0] usum;
  logic             wrap;

  assign psum = {1'b0, pcnt} + (CNT_W + 1)'(p_inc);
  assign usum = ucnt + CNT_W'(u_inc);
  assign wrap = psum[CNT_W];

  always_comb begin
    adj = ADJ_HOLD;
    if (wrap) begin
      if (int'(usum) > HI_TH)      adj = ADJ_UP;
      else if (int'(usum) < LO_TH) adj = ADJ_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt <= '0;
      ucnt <= '0;
    end else begin
      pcnt <= psum[CNT_W-1:0];
      ucnt <= wrap ? '0 : usum;
    end
  end
endmodule

// File: rtl/pfdeg_lookahead.sv
// Saturating degree register with registered enable.
module pfdeg_lookahead
  import pfdeg_pkg::*;
#(
  parameter int LA_MAX = 7,
  parameter int LA_W   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  adj_e            adj,
  output logic [LA_W-1:0] la,
  output logic            en
);
  logic [LA_W-1:0] la_nx;

  always_comb begin
    la_nx = la;
    case (adj)
      ADJ_UP:   if (la != LA_W'(LA_MAX)) la_nx = la + 1'b1;
      ADJ_DOWN: if (la != '0)            la_nx = la - 1'b1;
      default:  la_nx = la;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      la <= LA_W'(1);
      en <= 1'b1;
    end else begin
      la <= la_nx;
      en <= (la_nx != '0);
    end
  end
endmodule

// File: rtl/pf_degree_ctrl.sv
module pf_degree_ctrl
  import pfdeg_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int CNT_W  = 4,
  parameter int LA_MAX = 7,
  parameter int HI_TH  = 12,
  parameter int LO_TH  = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int LA_W  = $clog2(LA_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rply_vld,
  input  logic             pfill_vld,
  input  logic [IDX_W-1:0] pfill_idx,
  input  logic             acc_vld,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             dfill_vld,
  input  logic [IDX_W-1:0] dfill_idx,
  input  logic             prev_vld,
  input  logic             prev_hit,
  input  logic [IDX_W-1:0] prev_idx,
  output logic [LA_W-1:0]  degree,
  output logic             pf_en
);
  logic       pf_on;
  logic       pb_use, zb_use;
  logic [1:0] p_inc, u_inc;
  adj_e       adj;

  assign pf_on = (degree != '0);
  assign p_inc = {1'b0, rply_vld} + {1'b0, dfill_vld & ~pf_on};
  assign u_inc = {1'b0, pb_use} + {1'b0, zb_use};

  pfdeg_linebits #(.LINES(LINES), .IW(IDX_W)) u_bits (
    .clk(clk), .rst(rst), .pf_on(pf_on),
    .pfill_vld(pfill_vld), .pfill_idx(pfill_idx),
    .acc_vld(acc_vld), .acc_idx(acc_idx),
    .dfill_vld(dfill_vld), .dfill_idx(dfill_idx),
    .prev_vld(prev_vld), .prev_hit(prev_hit), .prev_idx(prev_idx),
    .pb_use(pb_use), .zb_use(zb_use)
  );

  pfdeg_window #(.CNT_W(CNT_W), .HI_TH(HI_TH), .LO_TH(LO_TH)) u_win (
    .clk(clk), .rst(rst), .p_inc(p_inc), .u_inc(u_inc), .adj(adj)
  );

  pfdeg_lookahead #(.LA_MAX(LA_MAX), .LA_W(LA_W)) u_la (
    .clk(clk), .rst(rst), .adj(adj), .la(degree), .en(pf_en)
  );
endmodule

// File: rtl/pfdeg_chk.sv
module pfdeg_chk #(
  parameter int LA_MAX = 7,
  parameter int LA_W   = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            rply_vld,
  input logic            dfill_vld,
  input logic [LA_W-1:0] degree,
  input logic            pf_en
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (degree == LA_W'(1) && pf_en));

  a_r6_enable_tracks: assert property (@(posedge clk) disable iff (rst)
    pf_en == (degree != '0));

  a_r7_ceiling: assert property (@(posedge clk) disable iff (rst)
    int'(degree) <= LA_MAX);

  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    !$stable(degree) |->
      (int'(degree) == int'($past(degree)) + 1 ||
       int'(degree) + 1 == int'($past(degree))));

  a_r4_change_needs_count: assert property (@(posedge clk) disable iff (rst)
    !$stable(degree) |->
      $past(rply_vld || (dfill_vld && degree == '0)));
endmodule

bind pf_degree_ctrl pfdeg_chk #(.LA_MAX(LA_MAX), .LA_W(LA_W)) u_chk (
  .clk(clk), .rst(rst), .rply_vld(rply_vld), .dfill_vld(dfill_vld),
  .degree(degree), .pf_en(pf_en)
);

// File: tb/test_pf_degree_ctrl.sv
`timescale 1ns/1ps
module test_pf_degree_ctrl;
  localparam int LINES = 64;
  localparam int IW = 6;
  localparam int LAW = 3;
  localparam int LA_MAX = 7;
  localparam int HI_TH = 12;
  localparam int LO_TH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rply_vld = 0, pfill_vld = 0, acc_vld = 0, dfill_vld = 0;
  logic prev_vld = 0, prev_hit = 0;
  logic [IW-1:0] pfill_idx = '0, acc_idx = '0, dfill_idx = '0, prev_idx = '0;
  logic [LAW-1:0] degree;
  logic pf_en;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pf_degree_ctrl i_pf_degree_ctrl (
    .clk(clk), .rst(rst), .rply_vld(rply_vld),
    .pfill_vld(pfill_vld), .pfill_idx(pfill_idx),
    .acc_vld(acc_vld), .acc_idx(acc_idx),
    .dfill_vld(dfill_vld), .dfill_idx(dfill_idx),
    .prev_vld(prev_vld), .prev_hit(prev_hit), .prev_idx(prev_idx),
    .degree(degree), .pf_en(pf_en)
  );

  // behavioural reference model
  int  mla, mpc, muc;
  bit  mpb[LINES];
  bit  mzb[LINES];

  always @(posedge clk) begin
    if (rst) begin
      mla = 1; mpc = 0; muc = 0;
      foreach (mpb[i]) begin mpb[i] = 0; mzb[i] = 0; end
    end else begin
      int inc_p, inc_u, u;
      bit pb_seen, zb_seen;
      pb_seen = acc_vld && mpb[acc_idx];
      zb_seen = prev_vld && prev_hit && mzb[prev_idx];
      inc_u = int'(pb_seen) + int'(zb_seen);
      inc_p = int'(rply_vld) + int'(dfill_vld && mla == 0);
      if (acc_vld) mpb[acc_idx] = 0;
      if (acc_vld && mla != 0) mzb[acc_idx] = 0;
      if (prev_vld && prev_hit) mzb[prev_idx] = 0;
      if (pfill_vld) mpb[pfill_idx] = 1;
      if (dfill_vld && mla == 0) mzb[dfill_idx] = 1;
      u = (muc + inc_u) % 16;
      if (mpc + inc_p >= 16) begin
        if (u > HI_TH && mla < LA_MAX) mla = mla + 1;
        else if (u < LO_TH && mla > 0) mla = mla - 1;
        muc = 0;
      end else begin
        muc = u;
      end
      mpc = (mpc + inc_p) % 16;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(degree) == mla, "R5 degree vs model", int'(degree), mla);
      chk(pf_en == (mla != 0), "R6 enable vs model", int'(pf_en), int'(mla != 0));
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    rply_vld = 0; pfill_vld = 0; acc_vld = 0; dfill_vld = 0;
    prev_vld = 0; prev_hit = 0;
  endtask

  task automatic replies(input int n);
    for (int i = 0; i < n; i++) begin rply_vld = 1; tick(); end
  endtask

  task automatic pf_fill(input int idx);
    pfill_vld = 1; pfill_idx = IW'(idx); tick();
  endtask

  task automatic access(input int idx);
    acc_vld = 1; acc_idx = IW'(idx); tick();
  endtask

  task automatic dm_fill(input int idx);
    dfill_vld = 1; dfill_idx = IW'(idx); tick();
  endtask

  task automatic prev_look(input int idx, input bit hit);
    prev_vld = 1; prev_hit = hit; prev_idx = IW'(idx); tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 0;
    // R1
    chk(degree == 3'd1, "R1 reset degree", int'(degree), 1);
    chk(pf_en == 1'b1, "R1 reset enable", int'(pf_en), 1);

    // R2/R4: 15 replies (data or nack alike) do not yet adjust
    replies(15);
    chk(degree == 3'd1, "R4 no change before wrap", int'(degree), 1);
    // R5: wrap with zero hits lowers the degree
    replies(1);
    chk(degree == 3'd0, "R5 low hits decrement", int'(degree), 0);
    chk(pf_en == 1'b0, "R6 disabled at zero", int'(pf_en), 0);
    // R7 floor
    replies(16);
    chk(degree == 3'd0, "R7 floor at zero", int'(degree), 0);

    // R8/R4: reply and demand fill together count two
    rply_vld = 1; dfill_vld = 1; dfill_idx = IW'(0); tick();
    for (int i = 1; i < 14; i++) dm_fill(i);      // count now 15
    access(0);                                   // R10: off, zero flag kept
    for (int i = 0; i < 13; i++) prev_look(i, 1); // R9: 13 hits
    prev_look(13, 0);                            // R9: miss ignored
    chk(degree == 3'd0, "R8 off before wrap", int'(degree), 0);
    dm_fill(14);                                 // wrap, hits 13 > 12
    chk(degree == 3'd1, "R9 recovery from zero", int'(degree), 1);
    chk(pf_en == 1'b1, "R6 re-enabled", int'(pf_en), 1);

    // R10: access with degree on clears zero flag of line 13
    access(13);
    for (int i = 20; i < 31; i++) pf_fill(i);
    for (int i = 20; i < 31; i++) access(i);     // R3: 11 hits
    access(20);                                  // R3: no second count
    prev_look(13, 1);                            // R10: already cleared
    prev_look(14, 1);                            // 12 hits
    replies(16);
    chk(degree == 3'd1, "R10 hits at threshold hold", int'(degree), 1);

    // R11: same-cycle fill and access, hit counted in wrap cycle
    pfill_vld = 1; pfill_idx = IW'(40); acc_vld = 1; acc_idx = IW'(40); tick();
    for (int i = 41; i < 53; i++) pf_fill(i);
    for (int i = 41; i < 53; i++) access(i);     // 12 hits
    replies(15);
    chk(degree == 3'd1, "R11 before wrap", int'(degree), 1);
    rply_vld = 1; acc_vld = 1; acc_idx = IW'(40); tick();
    chk(degree == 3'd2, "R11 wrap-cycle hit counted", int'(degree), 2);

    // R7 ceiling
    for (int w = 0; w < 6; w++) begin
      for (int i = 0; i < 13; i++) pf_fill(i);
      for (int i = 0; i < 13; i++) access(i);
      replies(16);
    end
    chk(degree == 3'd7, "R7 saturates at max", int'(degree), LA_MAX);

    // random phase, model compared each cycle
    for (int c = 0; c < 4000; c++) begin
      rply_vld  = ($urandom_range(0, 99) < 50);
      pfill_vld = ($urandom_range(0, 99) < 30);
      pfill_idx = IW'($urandom_range(0, 15));
      acc_vld   = ($urandom_range(0, 99) < 40);
      acc_idx   = IW'($urandom_range(0, 15));
      dfill_vld = ($urandom_range(0, 99) < 25);
      dfill_idx = IW'($urandom_range(0, 15));
      prev_vld  = ($urandom_range(0, 99) < 35);
      prev_hit  = ($urandom_range(0, 99) < 70);
      prev_idx  = IW'($urandom_range(0, 15));
      tick();
    end

    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule